// File: doc/BRIEF.md
# Timer Interrupt Controller with Read-Clear

This block pairs a 16-bit down-counting timer with an interrupt flag and mask register, all on a small 8-bit register bus with separate read and write strobes. Software loads a reload value through two byte-wide latch registers and starts the timer through a control register. When the count passes through zero, the timer raises an interrupt flag. If the mask bit for that flag is set, the active-low interrupt request goes low.

The status register clears on read. Any bus cycle that strobes a read at the status address clears every pending flag on that clock edge. This includes a read whose data nobody uses, such as a processor dummy read. A mask write uses its top data bit to choose between setting and clearing the selected mask bits. A second flag position is reserved for a future source. It has a mask bit, but nothing ever raises it.

The timer is a two-state machine. TMR_STOPPED moves to TMR_RUNNING on the *start* transition, which is a control write with the run bit high. TMR_RUNNING moves back to TMR_STOPPED on the *halt* transition, which is a control write with the run bit low, or on the *one-shot expiry* transition, which is an underflow while one-shot mode is selected. A control write with the run bit high while running keeps the state (*keep*).

Top module: `tic_timer_irq`

## Requirements
- R1: After reset, irq_n is 1, both flags and both mask bits are 0, the timer is in TMR_STOPPED with one-shot off, and both the count and the latch hold 0xFFFF.
- R2: A read at address 2 returns the flags in bits [1:0], 0 in bits [6:2], and in bit 7 a 1 when any flag is pending with its mask bit set. Every read strobe at address 2 clears all flags at that clock edge.
- R3: A write to address 2 with data bit 7 = 1 sets each mask bit whose data bit in [1:0] is 1. With bit 7 = 0 it clears those mask bits. 0x81 enables the timer source (bit 0), and 0x7F disables every source.
- R4: irq_n is 0 exactly when some flag and its mask bit are both 1. It follows a flag or mask change in the cycle after the edge that made the change.
- R5: An underflow sets flag bit 0 whether or not mask bit 0 is set.
- R6: In TMR_RUNNING the count drops by one each cycle. A cycle that starts at count 0 is an underflow cycle, and it reloads the latch value. An irq therefore appears latch+1 cycles after the start, so a latch of 0xFFFF gives one underflow per 65536 cycles.
- R7: Control register at address 3: bit 0 is run, bit 3 selects one-shot mode (the *one-shot expiry* transition reloads the count and stops the timer), and bit 4 is a force-load strobe that copies the latch into the count at that edge. A read returns run in bit 0, one-shot in bit 3, and 0 in every other bit, including bit 4.
- R8: A write to address 0 sets the low latch byte, and a write to address 1 sets the high latch byte; neither changes the count. A read of address 0 or 1 returns the live count's low or high byte.
- R9: If an underflow falls in the same cycle as a clearing read, flag bit 0 is 1 after that edge.
- R10: Flag bit 1 is reserved. It is never set, and setting its mask bit never causes irq_n to go low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe for the current bus cycle |
| wr_en | input | 1 | Write strobe for the current bus cycle |
| addr | input | 2 | Register select: 0 count/latch low, 1 count/latch high, 2 status/mask, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register (combinational) |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A corrupted count shows at the count read ports at once. It also shifts the next falling edge of irq_n by the size of the error, so the period measurements catch it within one timer period. A flag or mask register in the wrong state shows on irq_n in the very next cycle, and on bit 7 of the status read. A lost flag from a read-clear collision leaves irq_n high at the edge where it should have fallen. A wrong machine state, such as a timer that keeps running after a one-shot expiry or a halt, shows as a count that keeps changing between two reads of the stopped timer.

// File: rtl/tic_pkg.sv
package tic_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CNT_LO = 2'd0,
        REG_CNT_HI = 2'd1,
        REG_ICR    = 2'd2,
        REG_CTRL   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        TMR_STOPPED = 1'b0,
        TMR_RUNNING = 1'b1
    } tmr_state_e;

    localparam int CTRL_RUN_BIT     = 0;
    localparam int CTRL_ONESHOT_BIT = 3;
    localparam int CTRL_LOAD_BIT    = 4;
    localparam int ICR_SETCLR_BIT   = 7;
    localparam int ICR_PEND_BIT     = 7;
endpackage

// File: rtl/tic_bus.sv
module tic_bus
    import tic_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_SRC = 2
) (
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [CNT_W-1:0]     count,
    input  logic                 running,
    input  logic                 oneshot,
    input  logic [N_SRC-1:0]     flags,
    input  logic                 pending,
    output logic                 wr_lat_lo,
    output logic                 wr_lat_hi,
    output logic                 wr_mask,
    output logic                 wr_ctrl,
    output logic                 rd_clr,
    output logic [DATA_W-1:0]    rdata
);
    localparam int HI_W  = CNT_W - DATA_W;
    localparam int PAD_W = DATA_W - 1 - N_SRC;

    reg_sel_e sel;

    always_comb begin
        sel       = reg_sel_e'(addr);
        wr_lat_lo = wr_en && (sel == REG_CNT_LO);
        wr_lat_hi = wr_en && (sel == REG_CNT_HI);
        wr_mask   = wr_en && (sel == REG_ICR);
        wr_ctrl   = wr_en && (sel == REG_CTRL);
        rd_clr    = rd_en && (sel == REG_ICR);
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            REG_CNT_LO: rdata = count[DATA_W-1:0];
            REG_CNT_HI: rdata[HI_W-1:0] = count[CNT_W-1:DATA_W];
            REG_ICR:    rdata = {pending, {PAD_W{1'b0}}, flags};
            REG_CTRL: begin
                rdata[CTRL_RUN_BIT]     = running;
                rdata[CTRL_ONESHOT_BIT] = oneshot;
            end
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/tic_timer.sv
module tic_timer
    import tic_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lat_lo,
    input  logic              wr_lat_hi,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  latch,
    output logic              running,
    output logic              oneshot,
    output logic              underflow
);
    localparam int HI_W = CNT_W - DATA_W;

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] latch_q;
    logic             oneshot_q;
    logic             force_ld;

    assign force_ld  = wr_ctrl && wdata[CTRL_LOAD_BIT];
    assign running   = (state_q == TMR_RUNNING);
    assign underflow = running && (count_q == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TMR_STOPPED;
        else        state_q <= state_d;
    end

    // transitions: start, halt, keep, one-shot expiry
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_STOPPED: begin
                if (wr_ctrl && wdata[CTRL_RUN_BIT]) state_d = TMR_RUNNING;
            end
            TMR_RUNNING: begin
                if (wr_ctrl)
                    state_d = wdata[CTRL_RUN_BIT] ? TMR_RUNNING : TMR_STOPPED;
                else if (underflow && oneshot_q)
                    state_d = TMR_STOPPED;
            end
            default: state_d = TMR_STOPPED;
        endcase
    end

    // outputs of the machine: count and mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '1;
            oneshot_q <= 1'b0;
        end else begin
            if (force_ld)
                count_q <= latch_q;
            else if (underflow)
                count_q <= latch_q;
            else if (state_q == TMR_RUNNING)
                count_q <= count_q - 1'b1;
            if (wr_ctrl)
                oneshot_q <= wdata[CTRL_ONESHOT_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '1;
        end else begin
            if (wr_lat_lo) latch_q[DATA_W-1:0]     <= wdata;
            if (wr_lat_hi) latch_q[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
        end
    end

    assign count   = count_q;
    assign latch   = latch_q;
    assign oneshot = oneshot_q;
endmodule

// File: rtl/tic_irq.sv
module tic_irq #(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mask,
    input  logic             mask_set,
    input  logic [N_SRC-1:0] mask_sel,
    input  logic             rd_clr,
    input  logic [N_SRC-1:0] src_event,
    output logic [N_SRC-1:0] flags,
    output logic [N_SRC-1:0] mask,
    output logic             pending,
    output logic             irq_n
);
    logic [N_SRC-1:0] flags_q;
    logic [N_SRC-1:0] mask_q;

    // a new event wins over a clearing read in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)      flags_q <= '0;
        else if (rd_clr) flags_q <= src_event;
        else             flags_q <= flags_q | src_event;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[i] <= 1'b0;
            else if (wr_mask && mask_sel[i])
                mask_q[i] <= mask_set;
        end
    end

    assign flags   = flags_q;
    assign mask    = mask_q;
    assign pending = |(flags_q & mask_q);
    assign irq_n   = ~pending;
endmodule

// File: rtl/tic_timer_irq.sv
module tic_timer_irq
    import tic_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_SRC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              irq_n
);
    logic             wr_lat_lo, wr_lat_hi, wr_mask, wr_ctrl, rd_clr;
    logic [CNT_W-1:0] count_w, latch_w;
    logic             running_w, oneshot_w, underflow_w;
    logic [N_SRC-1:0] flags_w, mask_w, src_event;
    logic             pending_w;

    if (N_SRC > 1) begin : g_src_pad
        assign src_event = {{(N_SRC-1){1'b0}}, underflow_w};
    end else begin : g_src_one
        assign src_event = underflow_w;
    end

    tic_bus #(.CNT_W(CNT_W), .N_SRC(N_SRC)) bus_i (
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .addr      (addr),
        .count     (count_w),
        .running   (running_w),
        .oneshot   (oneshot_w),
        .flags     (flags_w),
        .pending   (pending_w),
        .wr_lat_lo (wr_lat_lo),
        .wr_lat_hi (wr_lat_hi),
        .wr_mask   (wr_mask),
        .wr_ctrl   (wr_ctrl),
        .rd_clr    (rd_clr),
        .rdata     (rdata)
    );

    tic_timer #(.CNT_W(CNT_W)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lat_lo (wr_lat_lo),
        .wr_lat_hi (wr_lat_hi),
        .wr_ctrl   (wr_ctrl),
        .wdata     (wdata),
        .count     (count_w),
        .latch     (latch_w),
        .running   (running_w),
        .oneshot   (oneshot_w),
        .underflow (underflow_w)
    );

    tic_irq #(.N_SRC(N_SRC)) irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mask   (wr_mask),
        .mask_set  (wdata[ICR_SETCLR_BIT]),
        .mask_sel  (wdata[N_SRC-1:0]),
        .rd_clr    (rd_clr),
        .src_event (src_event),
        .flags     (flags_w),
        .mask      (mask_w),
        .pending   (pending_w),
        .irq_n     (irq_n)
    );
endmodule

// File: rtl/tic_checker.sv
module tic_checker
    import tic_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_SRC = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [7:0]       wdata,
    input logic [7:0]       rdata,
    input logic             irq_n,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] latch,
    input logic             running,
    input logic             underflow,
    input logic [N_SRC-1:0] flags,
    input logic [N_SRC-1:0] mask
);
    logic ctrl_wr, icr_rd;
    assign ctrl_wr = wr_en && (addr == REG_CTRL);
    assign icr_rd  = rd_en && (addr == REG_ICR);

    assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (icr_rd && !underflow) |=> (flags == '0));

    assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_ICR && wdata[ICR_SETCLR_BIT])
        |=> ((mask & $past(wdata[N_SRC-1:0])) == $past(wdata[N_SRC-1:0])));

    assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_ICR && !wdata[ICR_SETCLR_BIT])
        |=> ((mask & $past(wdata[N_SRC-1:0])) == '0));

    assert_irq_shows_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == REG_ICR && !irq_n) |-> rdata[ICR_PEND_BIT]);

    assert_underflow_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> flags[0]);

    assert_decrement_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !underflow && !ctrl_wr) |=> (count == $past(count) - 1'b1));

    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !ctrl_wr) |=> (count == $past(latch)));

    assert_force_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata[CTRL_LOAD_BIT]) |=> (count == $past(latch)));

    assert_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wdata[CTRL_RUN_BIT]) |=> !running);

    assert_load_bit_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == REG_CTRL) |-> !rdata[CTRL_LOAD_BIT]);

    assert_latch_write_keeps_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == REG_CNT_LO || addr == REG_CNT_HI) && !running) |=> $stable(count));

    assert_collision_keeps_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && icr_rd) |=> flags[0]);

    assert_reserved_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !flags[N_SRC-1]);
endmodule

bind tic_timer_irq tic_checker #(.CNT_W(CNT_W), .N_SRC(N_SRC)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .irq_n     (irq_n),
    .count     (count_w),
    .latch     (latch_w),
    .running   (running_w),
    .underflow (underflow_w),
    .flags     (flags_w),
    .mask      (mask_w)
);

// File: tb/tic_timer_irq_tb_top.sv
`timescale 1ns/1ps
module tic_timer_irq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state
    int unsigned m_cnt, m_latch;
    bit          m_run, m_os;
    bit [1:0]    m_flag, m_mask;

    always #2 clk = ~clk;

    tic_timer_irq dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_read(input int a);
        case (a)
            0: return m_cnt & 'hFF;
            1: return (m_cnt >> 8) & 'hFF;
            2: return ((m_flag & m_mask) != 0 ? 'h80 : 0) | m_flag;
            default: return (m_os ? 'h08 : 0) | (m_run ? 1 : 0);
        endcase
    endfunction

    task automatic model_step();
        bit uf, wrc;
        uf  = m_run && (m_cnt == 0);
        wrc = wr_en && (addr == 2'd3);
        if (wrc && wdata[4])  m_cnt = m_latch;
        else if (uf)          m_cnt = m_latch;
        else if (m_run)       m_cnt = m_cnt - 1;
        if (wrc)              m_run = wdata[0];
        else if (uf && m_os)  m_run = 1'b0;
        if (wrc)              m_os = wdata[3];
        if (wr_en && addr == 2'd0) m_latch = (m_latch & 'hFF00) | wdata;
        if (wr_en && addr == 2'd1) m_latch = (m_latch & 'h00FF) | (int'(wdata) << 8);
        if (rd_en && addr == 2'd2) m_flag = 2'b00;
        if (uf) m_flag[0] = 1'b1;
        if (wr_en && addr == 2'd2) begin
            if (wdata[7]) m_mask = m_mask | wdata[1:0];
            else          m_mask = m_mask & ~wdata[1:0];
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 'hFFFF; m_latch = 'hFFFF; m_run = 0; m_os = 0;
            m_flag = 0; m_mask = 0;
        end else begin
            model_step();
        end
        #1;
        if (rst_n && !done) begin
            chk(irq_n == ((m_flag & m_mask) == 0), "R4 model irq_n", irq_n, (m_flag & m_mask) == 0);
            case (addr)
                2'd0, 2'd1: chk(rdata == model_read(addr), "R8 model count byte", rdata, model_read(addr));
                2'd2:       chk(rdata == model_read(addr), "R2 model status", rdata, model_read(addr));
                default:    chk(rdata == model_read(addr), "R7 model control", rdata, model_read(addr));
            endcase
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (irq_n && n < 70000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #600000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] d, d2;
        int n;
        idle(4);
        chk(irq_n == 1'b1, "R1 irq_n in reset", irq_n, 1);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        bus_read(2'd3, d); chk(d == 8'h00, "R1 control after reset", d, 8'h00);
        bus_read(2'd0, d); chk(d == 8'hFF, "R1 count low after reset", d, 8'hFF);
        bus_read(2'd1, d); chk(d == 8'hFF, "R1 count high after reset", d, 8'hFF);
        bus_read(2'd2, d); chk(d == 8'h00, "R1 status after reset", d, 8'h00);

        // R8 latch write does not touch the count; R7 force load
        bus_write(2'd0, 8'h05);
        bus_write(2'd1, 8'h00);
        bus_read(2'd0, d); chk(d == 8'hFF, "R8 count unchanged by latch write", d, 8'hFF);
        bus_write(2'd3, 8'h10);
        bus_read(2'd0, d); chk(d == 8'h05, "R7 force load low", d, 8'h05);
        bus_read(2'd1, d); chk(d == 8'h00, "R7 force load high", d, 8'h00);
        bus_read(2'd3, d); chk(d == 8'h00, "R7 load strobe reads 0", d, 8'h00);

        // R3 enable timer source, R6 continuous period
        bus_write(2'd2, 8'h81);
        chk(irq_n == 1'b1, "R4 no irq without flag", irq_n, 1);
        bus_write(2'd3, 8'h11);
        wait_irq(n);
        chk(n == 6, "R6 period latch+1", n, 6);
        bus_write(2'd3, 8'h00);
        bus_read(2'd2, d); chk(d == 8'h81, "R2 status with pending", d, 8'h81);
        chk(irq_n == 1'b1, "R2 irq released by read", irq_n, 1);
        bus_read(2'd2, d); chk(d == 8'h00, "R2 second read empty", d, 8'h00);

        // R7 one-shot
        bus_write(2'd3, 8'h19);
        wait_irq(n);
        chk(n == 6, "R7 one-shot delay", n, 6);
        idle(3);
        bus_read(2'd3, d); chk(d == 8'h08, "R7 one-shot stopped", d, 8'h08);
        bus_read(2'd0, d); chk(d == 8'h05, "R7 one-shot reloaded", d, 8'h05);
        bus_read(2'd2, d); chk(d == 8'h81, "R2 one-shot flag", d, 8'h81);

        // R7 halt freezes the count
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'h01);
        bus_write(2'd3, 8'h11);
        idle(10);
        bus_write(2'd3, 8'h00);
        bus_read(2'd0, d);
        idle(5);
        bus_read(2'd0, d2);
        chk(d == d2, "R7 halted count stable", d2, d);

        // R6 full-range period
        bus_write(2'd0, 8'hFF);
        bus_write(2'd1, 8'hFF);
        bus_write(2'd3, 8'h11);
        wait_irq(n);
        chk(n == 65536, "R6 period 65536", n, 65536);
        bus_write(2'd3, 8'h00);
        bus_read(2'd2, d); chk(d == 8'h81, "R2 flag after long period", d, 8'h81);

        // R8 live count bytes
        bus_write(2'd0, 8'h03);
        bus_write(2'd1, 8'h02);
        bus_write(2'd3, 8'h10);
        bus_read(2'd1, d); chk(d == 8'h02, "R8 count high byte", d, 8'h02);
        bus_read(2'd0, d); chk(d == 8'h03, "R8 count low byte", d, 8'h03);

        // R5 flag while masked, R3 mask set/clear
        bus_write(2'd0, 8'h05);
        bus_write(2'd1, 8'h00);
        bus_write(2'd2, 8'h01);
        bus_write(2'd3, 8'h19);
        idle(10);
        chk(irq_n == 1'b1, "R4 masked flag no irq", irq_n, 1);
        bus_read(2'd2, d); chk(d == 8'h01, "R5 flag set while masked", d, 8'h01);
        bus_write(2'd3, 8'h19);
        idle(10);
        bus_write(2'd2, 8'h81);
        chk(irq_n == 1'b0, "R3 0x81 enables timer irq", irq_n, 0);
        bus_write(2'd2, 8'h7F);
        chk(irq_n == 1'b1, "R3 0x7F disables all", irq_n, 1);
        bus_read(2'd2, d); chk(d == 8'h01, "R3 flag kept, not pending", d, 8'h01);

        // R9 underflow coinciding with a clearing read
        bus_write(2'd2, 8'h81);
        bus_write(2'd3, 8'h19);
        idle(4);
        bus_read(2'd2, d);
        chk(d == 8'h00, "R9 read before flag", d, 8'h00);
        chk(irq_n == 1'b0, "R9 flag survives collision", irq_n, 0);
        bus_read(2'd2, d); chk(d == 8'h81, "R9 flag readable", d, 8'h81);

        // R10 reserved source
        bus_write(2'd2, 8'h82);
        idle(5);
        chk(irq_n == 1'b1, "R10 reserved mask gives no irq", irq_n, 1);
        bus_write(2'd3, 8'h19);
        idle(10);
        bus_read(2'd2, d); chk(d == 8'h81, "R10 reserved flag stays 0", d, 8'h81);

        idle(3);
        finish_run();
    end
endmodule